// File: doc/BRIEF.md
# Privilege and Control-Transfer Unit

This unit sits beside the execute stage of a small 32-bit pipelined core. It handles the instructions that a plain ALU cannot: return from a trap, the jump through a general register, moves in either direction between the general registers and a small special register file, the two numbered system calls, and the privileged host print and host read. It holds the one-bit status word (0 for user mode, 1 for privileged mode) and the special register file. That file holds the saved return PC, the trap cause and the host data word.

Each cycle with `issue_valid` high presents one instruction word with its PC. The unit drives a general-register read address at once, from the instruction alone. It takes the read value back in the same cycle. One clock edge later it produces registered results: a redirect pulse with its target, a fault pulse, a general-register write, or a host request. A system call traps. So does a privileged word issued in user mode. Either one saves the PC and a cause, raises privilege and redirects to `trap_vec`. The redirect pulse is the flush signal for younger instructions.

Top module: `priv_ctl_unit`

## Requirements
- R1: After a synchronous reset the status word is 1 (privileged) and every special register reads as zero. No redirect, fault, register write or host request is asserted while reset is high or in the first cycle after it.
- R2: The word 0x0000007F in privileged mode gives `redirect_valid` one cycle later, with `redirect_pc` equal to special register 0, and sets the status word to 0.
- R3: The words 0x0000007F, 0x0200007D and 0x0400007D issued in user mode are violations, and no host request results. One cycle later `fault_valid` and `redirect_valid` are high and `redirect_pc` equals `trap_vec`. Special register 0 holds the faulting PC, special register 1 holds cause 2, and the status word is 1.
- R4: The system calls 0x00600073 and 0x00700073 trap without `fault_valid`. They save the PC in special register 0, write cause 1 in special register 1, set the status word to 1 and redirect to `trap_vec`.
- R5: A word with bits [6:0] = 1101111 is a jump in either mode. `gpr_raddr` equals bits [19:15] in the same cycle. One cycle later a redirect goes to the value that was on `gpr_rdata`, whatever the other bits hold.
- R6: Opcode 0101111 with funct7 [31:25] = 0 writes a general register one cycle later. `gpr_waddr` is bits [11:7] and `gpr_wdata` is the special register that bits [21:20] select.
- R7: Opcode 0101111 with funct7 = 1 sets `gpr_raddr` to bits [21:20], zero-extended, in the same cycle. The value on `gpr_rdata` is stored into the special register that the low three bits of [11:7] select, and the next instruction sees it.
- R8: The word 0x0200007D in privileged mode pulses `host_tx_req` one cycle later, with `host_tx_data` equal to special register 4.
- R9: The word 0x0400007D in privileged mode pulses `host_rx_req` one cycle later. `host_rx_valid` stores `host_rx_data` into special register 4. A move into register 4 in the same cycle takes precedence.
- R10: With `issue_valid` low, or for any other word, the status word, the special registers and all outputs stay unchanged, and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | PC of the instruction word |
| trap_vec | input | 32 | Trap entry address |
| gpr_raddr | output | 5 | General register read index (combinational) |
| gpr_rdata | input | 32 | Value of the general register named by `gpr_raddr` |
| host_rx_valid | input | 1 | Host delivers a data word |
| host_rx_data | input | 32 | Data word from the host |
| priv_mode | output | 1 | Status word: 1 privileged, 0 user |
| redirect_valid | output | 1 | One-cycle redirect and flush pulse |
| redirect_pc | output | 32 | Redirect target |
| fault_valid | output | 1 | Privilege violation pulse |
| gpr_we | output | 1 | General register write strobe |
| gpr_waddr | output | 5 | General register write index |
| gpr_wdata | output | 32 | General register write data |
| host_tx_req | output | 1 | Host print request pulse |
| host_tx_data | output | 32 | Data for the host print |
| host_rx_req | output | 1 | Host read request pulse |

## Verification
Only `gpr_raddr` is due in the issue cycle itself. The bench samples it shortly after driving the word, before the clock edge. Every pulse, every write-back field and the status word are due on the first edge after issue. The bench therefore drives on the falling edge and compares all outputs against its behavioural model on the next falling edge. The model's special registers change at that same edge, so the following instruction reads state as of that edge. Back-to-back pairs confirm this: a move in then out, and a trap followed by a read of the cause.

// File: rtl/priv_pkg.sv
package priv_pkg;

  localparam logic [31:0] WORD_TRAP_RET = 32'h0000_007F;
  localparam logic [31:0] WORD_HOST_TX  = 32'h0200_007D;
  localparam logic [31:0] WORD_HOST_RX  = 32'h0400_007D;
  localparam logic [31:0] WORD_CALL_TX  = 32'h0060_0073;
  localparam logic [31:0] WORD_CALL_RX  = 32'h0070_0073;
  localparam logic [6:0]  OPC_REG_JUMP  = 7'b110_1111;
  localparam logic [6:0]  OPC_SPR_MOVE  = 7'b010_1111;
  localparam logic [6:0]  F7_SPR_TO_GPR = 7'd0;
  localparam logic [6:0]  F7_GPR_TO_SPR = 7'd1;

  localparam logic [1:0]  CAUSE_SYSCALL = 2'd1;
  localparam logic [1:0]  CAUSE_PRIV    = 2'd2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRAP_RET,
    OP_JUMP,
    OP_SPR_RD,
    OP_SPR_WR,
    OP_SYSCALL,
    OP_HOST_TX,
    OP_HOST_RX
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       needs_priv;
    logic [4:0] gpr_src;
    logic [4:0] rd;
    logic [1:0] spr_src;
  } dec_t;

endpackage

// File: rtl/priv_decode.sv
module priv_decode
  import priv_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [6:0] opc;
  logic [6:0] f7;

  assign opc = instr[6:0];
  assign f7  = instr[31:25];

  always_comb begin
    dec            = '0;
    dec.op         = OP_NONE;
    dec.rd         = instr[11:7];
    dec.spr_src    = instr[21:20];
    dec.gpr_src    = instr[19:15];
    if (instr == WORD_TRAP_RET) begin
      dec.op         = OP_TRAP_RET;
      dec.needs_priv = 1'b1;
    end else if (instr == WORD_HOST_TX) begin
      dec.op         = OP_HOST_TX;
      dec.needs_priv = 1'b1;
    end else if (instr == WORD_HOST_RX) begin
      dec.op         = OP_HOST_RX;
      dec.needs_priv = 1'b1;
    end else if (instr == WORD_CALL_TX || instr == WORD_CALL_RX) begin
      dec.op         = OP_SYSCALL;
    end else if (opc == OPC_REG_JUMP) begin
      dec.op         = OP_JUMP;
    end else if (opc == OPC_SPR_MOVE && f7 == F7_SPR_TO_GPR) begin
      dec.op         = OP_SPR_RD;
    end else if (opc == OPC_SPR_MOVE && f7 == F7_GPR_TO_SPR) begin
      dec.op         = OP_SPR_WR;
      dec.gpr_src    = {3'b000, instr[21:20]};
    end
  end

endmodule

// File: rtl/priv_spr_file.sv
module priv_spr_file #(
  parameter int XLEN      = 32,
  parameter int DEPTH     = 8,
  parameter int RET_IDX   = 0,
  parameter int CAUSE_IDX = 1,
  parameter int IO_IDX    = 4,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_we,
  input  logic [XLEN-1:0]  trap_pc,
  input  logic [1:0]       trap_cause,
  input  logic             mts_we,
  input  logic [IDX_W-1:0] mts_idx,
  input  logic [XLEN-1:0]  mts_data,
  input  logic             host_we,
  input  logic [XLEN-1:0]  host_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic [XLEN-1:0]  ret_pc,
  output logic [XLEN-1:0]  io_data
);

  logic [XLEN-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (mts_we && mts_idx == IDX_W'(i))
          regs[i] <= mts_data;
        else if (trap_we && i == RET_IDX)
          regs[i] <= trap_pc;
        else if (trap_we && i == CAUSE_IDX)
          regs[i] <= XLEN'(trap_cause);
        else if (host_we && i == IO_IDX)
          regs[i] <= host_data;
      end
    end
  end

  assign rd_data = regs[rd_idx];
  assign ret_pc  = regs[RET_IDX];
  assign io_data = regs[IO_IDX];

endmodule

// File: rtl/priv_ctrl.sv
module priv_ctrl
  import priv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  op_e             op,
  input  logic            needs_priv,
  input  logic [4:0]      rd,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] trap_vec,
  input  logic [XLEN-1:0] gpr_rdata,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [XLEN-1:0] io_data,
  input  logic [XLEN-1:0] spr_rd_data,
  output logic            trap_we,
  output logic [1:0]      trap_cause,
  output logic            mts_we,
  output logic            priv_mode,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            fault_valid,
  output logic            gpr_we,
  output logic [4:0]      gpr_waddr,
  output logic [XLEN-1:0] gpr_wdata,
  output logic            host_tx_req,
  output logic [XLEN-1:0] host_tx_data,
  output logic            host_rx_req
);

  logic viol, syscall, do_ret, do_jump, do_tx, do_rx;

  always_comb begin
    viol    = issue_valid && needs_priv && !priv_mode;
    syscall = issue_valid && op == OP_SYSCALL;
    do_ret  = issue_valid && op == OP_TRAP_RET && priv_mode;
    do_jump = issue_valid && op == OP_JUMP;
    do_tx   = issue_valid && op == OP_HOST_TX && priv_mode;
    do_rx   = issue_valid && op == OP_HOST_RX && priv_mode;
  end

  assign trap_we    = viol || syscall;
  assign trap_cause = viol ? CAUSE_PRIV : CAUSE_SYSCALL;
  assign mts_we     = issue_valid && op == OP_SPR_WR;

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_mode      <= 1'b1;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      fault_valid    <= 1'b0;
      gpr_we         <= 1'b0;
      gpr_waddr      <= '0;
      gpr_wdata      <= '0;
      host_tx_req    <= 1'b0;
      host_tx_data   <= '0;
      host_rx_req    <= 1'b0;
    end else begin
      redirect_valid <= trap_we || do_ret || do_jump;
      if (trap_we)
        redirect_pc <= trap_vec;
      else if (do_ret)
        redirect_pc <= ret_pc;
      else if (do_jump)
        redirect_pc <= gpr_rdata;
      if (trap_we)
        priv_mode <= 1'b1;
      else if (do_ret)
        priv_mode <= 1'b0;
      fault_valid <= viol;
      gpr_we      <= issue_valid && op == OP_SPR_RD;
      if (issue_valid && op == OP_SPR_RD) begin
        gpr_waddr <= rd;
        gpr_wdata <= spr_rd_data;
      end
      host_tx_req <= do_tx;
      if (do_tx) host_tx_data <= io_data;
      host_rx_req <= do_rx;
    end
  end

endmodule

// File: rtl/priv_ctl_unit.sv
module priv_ctl_unit
  import priv_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int SPR_DEPTH = 8,
  parameter int IO_IDX    = 4,
  localparam int IDX_W    = $clog2(SPR_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] trap_vec,
  output logic [4:0]      gpr_raddr,
  input  logic [XLEN-1:0] gpr_rdata,
  input  logic            host_rx_valid,
  input  logic [XLEN-1:0] host_rx_data,
  output logic            priv_mode,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            fault_valid,
  output logic            gpr_we,
  output logic [4:0]      gpr_waddr,
  output logic [XLEN-1:0] gpr_wdata,
  output logic            host_tx_req,
  output logic [XLEN-1:0] host_tx_data,
  output logic            host_rx_req
);

  dec_t            dec;
  logic            trap_we, mts_we;
  logic [1:0]      trap_cause;
  logic [XLEN-1:0] spr_rd_data, ret_pc, io_data;

  priv_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign gpr_raddr = dec.gpr_src;

  priv_spr_file #(
    .XLEN      (XLEN),
    .DEPTH     (SPR_DEPTH),
    .RET_IDX   (0),
    .CAUSE_IDX (1),
    .IO_IDX    (IO_IDX)
  ) u_spr (
    .clk        (clk),
    .rst        (rst),
    .trap_we    (trap_we),
    .trap_pc    (pc),
    .trap_cause (trap_cause),
    .mts_we     (mts_we),
    .mts_idx    (dec.rd[IDX_W-1:0]),
    .mts_data   (gpr_rdata),
    .host_we    (host_rx_valid),
    .host_data  (host_rx_data),
    .rd_idx     (IDX_W'(dec.spr_src)),
    .rd_data    (spr_rd_data),
    .ret_pc     (ret_pc),
    .io_data    (io_data)
  );

  priv_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .issue_valid    (issue_valid),
    .op             (dec.op),
    .needs_priv     (dec.needs_priv),
    .rd             (dec.rd),
    .pc             (pc),
    .trap_vec       (trap_vec),
    .gpr_rdata      (gpr_rdata),
    .ret_pc         (ret_pc),
    .io_data        (io_data),
    .spr_rd_data    (spr_rd_data),
    .trap_we        (trap_we),
    .trap_cause     (trap_cause),
    .mts_we         (mts_we),
    .priv_mode      (priv_mode),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .fault_valid    (fault_valid),
    .gpr_we         (gpr_we),
    .gpr_waddr      (gpr_waddr),
    .gpr_wdata      (gpr_wdata),
    .host_tx_req    (host_tx_req),
    .host_tx_data   (host_tx_data),
    .host_rx_req    (host_rx_req)
  );

endmodule

// File: rtl/priv_ctl_unit_chk.sv
module priv_ctl_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] trap_vec,
  input logic [XLEN-1:0] gpr_rdata,
  input logic            priv_mode,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            fault_valid,
  input logic            gpr_we,
  input logic            host_tx_req,
  input logic            host_rx_req
);

  AST_RET_TO_USER: assert property (@(posedge clk) disable iff (rst)
    issue_valid && instr == 32'h0000_007F && priv_mode |=> redirect_valid && !priv_mode); // R2

  AST_FAULT_TRAPS: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> redirect_valid && priv_mode && redirect_pc == $past(trap_vec)); // R3

  AST_USER_NO_HOST: assert property (@(posedge clk) disable iff (rst)
    issue_valid && !priv_mode |=> !host_tx_req && !host_rx_req); // R3

  AST_SYSCALL_TRAP: assert property (@(posedge clk) disable iff (rst)
    issue_valid && (instr == 32'h0060_0073 || instr == 32'h0070_0073)
    |=> redirect_valid && !fault_valid && priv_mode); // R4

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    issue_valid && instr[6:0] == 7'b110_1111 |=> redirect_valid && redirect_pc == $past(gpr_rdata)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !redirect_valid && !fault_valid && !gpr_we && !host_tx_req && !host_rx_req); // R10

endmodule

bind priv_ctl_unit priv_ctl_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .issue_valid    (issue_valid),
  .instr          (instr),
  .trap_vec       (trap_vec),
  .gpr_rdata      (gpr_rdata),
  .priv_mode      (priv_mode),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .fault_valid    (fault_valid),
  .gpr_we         (gpr_we),
  .host_tx_req    (host_tx_req),
  .host_rx_req    (host_rx_req)
);

// File: tb/priv_ctl_unit_bench.sv
`timescale 1ns/1ps
module priv_ctl_unit_bench;

  localparam logic [31:0] TVEC = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue_valid;
  logic [31:0] instr, pc, trap_vec, gpr_rdata, host_rx_data;
  logic        host_rx_valid;
  logic [4:0]  gpr_raddr, gpr_waddr;
  logic        priv_mode, redirect_valid, fault_valid, gpr_we, host_tx_req, host_rx_req;
  logic [31:0] redirect_pc, gpr_wdata, host_tx_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic        m_mode;
  logic [31:0] m_spr [8];
  logic [31:0] cur_pc;

  always #2.5 clk = ~clk;

  priv_ctl_unit u_priv_ctl_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr), .pc(pc),
    .trap_vec(trap_vec), .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
    .host_rx_valid(host_rx_valid), .host_rx_data(host_rx_data),
    .priv_mode(priv_mode), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .fault_valid(fault_valid), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata), .host_tx_req(host_tx_req), .host_tx_data(host_tx_data),
    .host_rx_req(host_rx_req)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mfs(input int rd, input int src);
    return (32'(src) << 20) | (32'(rd) << 7) | 32'h2F;
  endfunction

  function automatic logic [31:0] mk_mts(input int sdst, input int gsrc);
    return (32'd1 << 25) | (32'(gsrc) << 20) | (32'(sdst) << 7) | 32'h2F;
  endfunction

  function automatic logic [31:0] mk_jmp(input int rs, input logic [31:0] junk);
    return (junk & 32'hFFF0_7F80) | (32'(rs) << 15) | 32'h6F;
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] rdv,
                      input logic rxv, input logic [31:0] rxd, input string req);
    logic is_ret, is_tx, is_rx, is_call, is_jmp, is_mfs, is_mts, viol, trap;
    logic e_redir, e_fault, e_we, e_tx, e_rx, nm;
    logic [31:0] e_rpc, e_wdata, e_txd;
    logic [4:0]  e_waddr;
    logic [31:0] nspr [8];
    issue_valid = v; instr = ins; pc = cur_pc; gpr_rdata = rdv;
    host_rx_valid = rxv; host_rx_data = rxd;
    is_ret  = ins == 32'h0000_007F;
    is_tx   = ins == 32'h0200_007D;
    is_rx   = ins == 32'h0400_007D;
    is_call = ins == 32'h0060_0073 || ins == 32'h0070_0073;
    is_jmp  = ins[6:0] == 7'h6F;
    is_mfs  = ins[6:0] == 7'h2F && ins[31:25] == 7'd0;
    is_mts  = ins[6:0] == 7'h2F && ins[31:25] == 7'd1;
    #1;
    if (v && is_jmp) chk(req, "gpr_raddr jump", 32'(gpr_raddr), 32'(ins[19:15]));
    if (v && is_mts) chk(req, "gpr_raddr move", 32'(gpr_raddr), 32'(ins[21:20]));
    viol    = v && (is_ret || is_tx || is_rx) && !m_mode;
    trap    = viol || (v && is_call);
    e_redir = trap || (v && is_ret && m_mode) || (v && is_jmp);
    e_rpc   = trap ? trap_vec : (is_ret ? m_spr[0] : rdv);
    e_fault = viol;
    e_we    = v && is_mfs;
    e_waddr = ins[11:7];
    e_wdata = m_spr[ins[21:20]];
    e_tx    = v && is_tx && m_mode;
    e_txd   = m_spr[4];
    e_rx    = v && is_rx && m_mode;
    nm      = m_mode;
    nspr    = m_spr;
    if (trap) begin
      nspr[0] = cur_pc;
      nspr[1] = viol ? 32'd2 : 32'd1;
      nm = 1'b1;
    end
    if (v && is_ret && m_mode) nm = 1'b0;
    if (rxv) nspr[4] = rxd;
    if (v && is_mts) nspr[ins[9:7]] = rdv;
    @(posedge clk);
    @(negedge clk);
    chk(req, "redirect_valid", 32'(redirect_valid), 32'(e_redir));
    if (e_redir) chk(req, "redirect_pc", redirect_pc, e_rpc);
    chk(req, "fault_valid", 32'(fault_valid), 32'(e_fault));
    chk(req, "gpr_we", 32'(gpr_we), 32'(e_we));
    if (e_we) begin
      chk(req, "gpr_waddr", 32'(gpr_waddr), 32'(e_waddr));
      chk(req, "gpr_wdata", gpr_wdata, e_wdata);
    end
    chk(req, "host_tx_req", 32'(host_tx_req), 32'(e_tx));
    if (e_tx) chk(req, "host_tx_data", host_tx_data, e_txd);
    chk(req, "host_rx_req", 32'(host_rx_req), 32'(e_rx));
    chk(req, "priv_mode", 32'(priv_mode), 32'(nm));
    m_mode = nm;
    m_spr  = nspr;
    cur_pc = cur_pc + 32'd4;
  endtask

  task automatic run(input logic [31:0] ins, input logic [31:0] rdv, input string req);
    step(1'b1, ins, rdv, 1'b0, 32'h0, req);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; issue_valid = 1'b0; instr = 32'h0000_007F; pc = 32'h0;
    trap_vec = TVEC; gpr_rdata = 32'h0; host_rx_valid = 1'b0; host_rx_data = 32'h0;
    m_mode = 1'b1; cur_pc = 32'h0000_1000;
    for (int i = 0; i < 8; i++) m_spr[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "priv_mode in reset", 32'(priv_mode), 32'd1);
    chk("R1", "redirect_valid in reset", 32'(redirect_valid), 32'd0);
    chk("R1", "fault_valid in reset", 32'(fault_valid), 32'd0);
    chk("R1", "gpr_we in reset", 32'(gpr_we), 32'd0);
    chk("R1", "host_tx_req in reset", 32'(host_tx_req), 32'd0);
    rst = 1'b0;
    step(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R1");
    run(mk_mfs(3, 2), 32'h0, "R1");
    run(mk_mfs(4, 1), 32'h0, "R1");

    // R7 then R6: move in, move out back to back
    run(mk_mts(3, 2), 32'hDEAD_BEEF, "R7");
    run(mk_mfs(7, 3), 32'h0, "R6");
    run(mk_mts(5'b11100, 1), 32'h1234_5678, "R7");
    // R8: print
    run(32'h0200_007D, 32'h0, "R8");
    // R9: read request, host data, precedence
    run(32'h0400_007D, 32'h0, "R9");
    step(1'b0, 32'h0, 32'h0, 1'b1, 32'hCAFE_0001, "R9");
    run(32'h0200_007D, 32'h0, "R9");
    step(1'b1, mk_mts(4, 2), 32'h0000_0055, 1'b1, 32'h0000_0066, "R9");
    run(32'h0200_007D, 32'h0, "R9");

    // R2: return to user
    run(mk_mts(0, 1), 32'h0000_0400, "R7");
    run(32'h0000_007F, 32'h0, "R2");
    // R3: user print traps, cause and PC saved
    run(32'h0200_007D, 32'h0, "R3");
    run(mk_mfs(1, 1), 32'h0, "R3");
    run(mk_mfs(2, 0), 32'h0, "R3");
    run(mk_mts(0, 1), 32'h0000_0800, "R7");
    run(32'h0000_007F, 32'h0, "R2");
    run(32'h0400_007D, 32'h0, "R3");
    run(mk_mfs(6, 1), 32'h0, "R3");
    run(32'h0000_007F, 32'h0, "R2");
    run(32'h0000_007F, 32'h0, "R3");
    run(mk_mfs(6, 0), 32'h0, "R3");

    // R4: system calls
    run(32'h0000_007F, 32'h0, "R2");
    run(32'h0060_0073, 32'h0, "R4");
    run(mk_mfs(9, 1), 32'h0, "R4");
    run(32'h0000_007F, 32'h0, "R2");
    trap_vec = 32'h0000_0300;
    run(32'h0070_0073, 32'h0, "R4");
    run(mk_mfs(9, 0), 32'h0, "R4");

    // R5: jump in both modes, junk bits ignored
    run(mk_jmp(9, 32'h0), 32'h0000_4444, "R5");
    run(32'h0000_007F, 32'h0, "R2");
    run(mk_jmp(31, 32'hFFFF_FFFF), 32'h8000_0010, "R5");
    run(mk_jmp(1, 32'hA5A5_5A5A), 32'h0000_0020, "R5");

    // R10: ignored stimulus
    step(1'b0, 32'h0000_007F, 32'h0, 1'b0, 32'h0, "R10");
    step(1'b0, 32'h0200_007D, 32'h0, 1'b0, 32'h0, "R10");
    run(32'h0000_0013, 32'h0, "R10");
    run(32'h0400_002F, 32'h0000_0777, "R10");
    run(32'h0000_0073, 32'h0, "R10");
    run(mk_mfs(5, 0), 32'h0, "R10");
    run(mk_mfs(5, 1), 32'h0, "R10");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule